// File: doc/BRIEF.md
# Link Receive Character Parser

This block sits on the receive side of a serial link and runs on the receive clock. Each cycle it takes in one 10-bit line character and four line-quality inputs: a byte-sync marker, a receiver-lock indication, a receive-error indication and a link-active indication. Every input is registered once. The block then sorts each character into data, end of frame, idle, variable-length-frame marker or illegal. It follows frame alignment, which starts at a byte-sync, and passes payload bytes downstream with a valid strobe. It also gives a one-cycle end-of-frame pulse.

Several conditions make the block drop the frame in progress and hunt for the next byte-sync. These are an illegal character, a receive error, and a loss of lock. After a loss of lock, the block also waits out a fixed settling interval before it hunts again. While the link is inactive, the parser freezes. The block keeps a saturating link-error count, a sticky link-error flag and a sticky link-state-change flag. It also provides delayed out-of-lock and active status bits for a register front end. That front end clears the count by reading it, and acknowledges the two flags with pulses.

Top module: `link_rx_parser`

## Requirements
- R1: A character whose type bits {bit 0, bit 5} equal 00 is data. If it is accepted inside a frame, byte_o shows {char[9:6], char[4:1]} with byte_valid_o high for one cycle, two rising edges after the character is applied.
- R2: A character of type 11 with data field 0xD0 gives a one-cycle eof_o and ends the frame. Type 11 with 0xEE (idle) or 0xFF (variable-length frame) gives no output and keeps the frame. eof_o and byte_valid_o are never high together.
- R3: Type 01, type 10, or type 11 with any other data field is illegal inside a frame. It drops the frame and adds one to the error count.
- R4: rx_err_i high (link active, locked, not settling) drops the frame and adds one to the error count, even while hunting.
- R5: While lock is low, no output is produced. After lock returns, 16 locked cycles pass before a byte-sync can be accepted. A character that arrives 15 cycles after the lock rise is ignored, and one that arrives 16 cycles after it is accepted.
- R6: While link-active is low, the parser is frozen. It produces no output and counts no errors, and the frame state is kept for when link-active returns.
- R7: While hunting, characters without byte-sync are ignored. A character that has byte-sync set starts a frame and is itself processed.
- R8: Any change of lock or link-active sets state_chg_o. The flag stays set until chg_ack_i, and a new change in the same cycle as the acknowledge wins.
- R9: The error count saturates at all ones. cnt_rd_i or lerr_ack_i clears it, and a clear in the same cycle as an increment leaves 1.
- R10: Every counted error sets link_err_o, which stays set until lerr_ack_i. A new error wins over the acknowledge.
- R11: out_of_lock_o is the inverse of lock, and link_act_o equals link-active. Both appear one rising edge after the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_char_i | input | 10 | Line character, type bits 0 and 5 |
| rx_bsync_i | input | 1 | Byte-sync marker for frame start |
| rx_lock_i | input | 1 | Receiver in lock |
| rx_err_i | input | 1 | Receiver flagged the character bad |
| rx_act_i | input | 1 | Link active |
| cnt_rd_i | input | 1 | Error count read, clears the count |
| lerr_ack_i | input | 1 | Link-error acknowledge, clears flag and count |
| chg_ack_i | input | 1 | State-change acknowledge |
| byte_o | output | 8 | Received payload byte |
| byte_valid_o | output | 1 | byte_o valid for this cycle |
| eof_o | output | 1 | End-of-frame pulse |
| err_cnt_o | output | 8 | Saturating link-error count |
| link_err_o | output | 1 | Sticky link-error flag |
| state_chg_o | output | 1 | Sticky lock/active change flag |
| out_of_lock_o | output | 1 | Delayed inverse of lock |
| link_act_o | output | 1 | Delayed link-active |

## Verification
Byte, end-of-frame, error-count and link-error results show up two rising edges after the character or error is applied. A change of lock or link-active reaches state_chg_o on the second edge, while the status bits follow their inputs after one edge. Clear and acknowledge pulses act on the same edge that samples them. The bench drives inputs on the falling edge and compares every output at each falling edge against a reference updated on the rising edge. It then runs directed sequences that read each result exactly one drive after the character that caused it, including the 15/16-cycle settling boundary and the edge where a clear meets an increment.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_SYNC, ST_HOLD} rx_state_e;
  typedef enum logic [2:0] {CH_DATA, CH_EOF, CH_IDLE, CH_VLF, CH_BAD} ch_kind_e;

  localparam logic [7:0] CODE_EOF  = 8'hD0;
  localparam logic [7:0] CODE_IDLE = 8'hEE;
  localparam logic [7:0] CODE_VLF  = 8'hFF;

  function automatic logic [7:0] char_payload(input logic [9:0] c);
    return {c[9:6], c[4:1]};
  endfunction

  function automatic logic [1:0] char_type(input logic [9:0] c);
    return {c[0], c[5]};
  endfunction
endpackage

// File: rtl/link_rx_sampler.sv
module link_rx_sampler #(
  parameter int CHAR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              bsync_i,
  input  logic              lock_i,
  input  logic              err_i,
  input  logic              act_i,
  output logic [CHAR_W-1:0] char_q_o,
  output logic              bsync_q_o,
  output logic              lock_q_o,
  output logic              err_q_o,
  output logic              act_q_o,
  output logic              lock_d_o,
  output logic              act_d_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_q_o  <= '0;
      bsync_q_o <= 1'b0;
      lock_q_o  <= 1'b0;
      err_q_o   <= 1'b0;
      act_q_o   <= 1'b0;
      lock_d_o  <= 1'b0;
      act_d_o   <= 1'b0;
    end else begin
      char_q_o  <= char_i;
      bsync_q_o <= bsync_i;
      lock_q_o  <= lock_i;
      err_q_o   <= err_i;
      act_q_o   <= act_i;
      lock_d_o  <= lock_q_o;
      act_d_o   <= act_q_o;
    end
  end
endmodule

// File: rtl/link_rx_classify.sv
module link_rx_classify
  import link_rx_pkg::*;
(
  input  logic [9:0] char_i,
  output ch_kind_e   kind_o,
  output logic [7:0] byte_o
);
  logic [1:0] ty;

  always_comb begin
    ty     = char_type(char_i);
    byte_o = char_payload(char_i);
    kind_o = CH_BAD;
    if (ty == 2'b00) kind_o = CH_DATA;
    else if (ty == 2'b11) begin
      unique case (byte_o)
        CODE_EOF:  kind_o = CH_EOF;
        CODE_IDLE: kind_o = CH_IDLE;
        CODE_VLF:  kind_o = CH_VLF;
        default:   kind_o = CH_BAD;
      endcase
    end
  end
endmodule

// File: rtl/link_rx_frame_fsm.sv
module link_rx_frame_fsm
  import link_rx_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ch_kind_e   kind_i,
  input  logic [7:0] byte_i,
  input  logic       bsync_i,
  input  logic       lock_i,
  input  logic       err_i,
  input  logic       act_i,
  output logic [7:0] byte_o,
  output logic       valid_o,
  output logic       eof_o,
  output logic       err_evt_o
);
  localparam int HCW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_CYC - 1);

  rx_state_e      st_q;
  logic [HCW-1:0] hcnt_q;
  logic           in_frame;
  logic           live;

  assign live      = act_i && lock_i && (st_q != ST_HOLD);
  assign in_frame  = (st_q == ST_SYNC) || bsync_i;
  assign err_evt_o = live && (err_i || (in_frame && kind_i == CH_BAD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HUNT;
      hcnt_q  <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
      eof_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      eof_o   <= 1'b0;
      if (act_i) begin
        if (!lock_i) begin
          st_q   <= ST_HOLD;
          hcnt_q <= '0;
        end else if (st_q == ST_HOLD) begin
          if (hcnt_q == HOLD_LAST) st_q <= ST_HUNT;
          else hcnt_q <= hcnt_q + 1'b1;
        end else if (err_i) begin
          st_q <= ST_HUNT;
        end else if (in_frame) begin
          unique case (kind_i)
            CH_DATA: begin
              st_q    <= ST_SYNC;
              byte_o  <= byte_i;
              valid_o <= 1'b1;
            end
            CH_EOF: begin
              st_q  <= ST_HUNT;
              eof_o <= 1'b1;
            end
            CH_IDLE, CH_VLF: st_q <= ST_SYNC;
            default: st_q <= ST_HUNT;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/link_rx_err_track.sv
module link_rx_err_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_evt_i,
  input  logic             cnt_rd_i,
  input  logic             lerr_ack_i,
  input  logic             chg_ack_i,
  input  logic             lock_q_i,
  input  logic             lock_d_i,
  input  logic             act_q_i,
  input  logic             act_d_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             lerr_o,
  output logic             chg_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic clr;
  logic chg_evt;

  assign clr     = cnt_rd_i || lerr_ack_i;
  assign chg_evt = (lock_q_i ^ lock_d_i) || (act_q_i ^ act_d_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      lerr_o <= 1'b0;
      chg_o  <= 1'b0;
    end else begin
      if (clr) cnt_o <= err_evt_i ? CNT_W'(1) : '0;
      else if (err_evt_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;

      if (err_evt_i) lerr_o <= 1'b1;
      else if (lerr_ack_i) lerr_o <= 1'b0;

      if (chg_evt) chg_o <= 1'b1;
      else if (chg_ack_i) chg_o <= 1'b0;
    end
  end
endmodule

// File: rtl/link_rx_parser.sv
module link_rx_parser
  import link_rx_pkg::*;
#(
  parameter int HOLD_CYC = 16,
  parameter int CNT_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [9:0]       rx_char_i,
  input  logic             rx_bsync_i,
  input  logic             rx_lock_i,
  input  logic             rx_err_i,
  input  logic             rx_act_i,
  input  logic             cnt_rd_i,
  input  logic             lerr_ack_i,
  input  logic             chg_ack_i,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o,
  output logic             eof_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             link_err_o,
  output logic             state_chg_o,
  output logic             out_of_lock_o,
  output logic             link_act_o
);
  logic [9:0] char_q;
  logic       bsync_q, lock_q, err_q, act_q, lock_d, act_d;
  ch_kind_e   kind;
  logic [7:0] payload;
  logic       err_evt;

  link_rx_sampler #(.CHAR_W(10)) u_smp (
    .clk_i, .rst_ni,
    .char_i(rx_char_i), .bsync_i(rx_bsync_i), .lock_i(rx_lock_i),
    .err_i(rx_err_i), .act_i(rx_act_i),
    .char_q_o(char_q), .bsync_q_o(bsync_q), .lock_q_o(lock_q),
    .err_q_o(err_q), .act_q_o(act_q), .lock_d_o(lock_d), .act_d_o(act_d)
  );

  link_rx_classify u_cls (
    .char_i(char_q), .kind_o(kind), .byte_o(payload)
  );

  link_rx_frame_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk_i, .rst_ni,
    .kind_i(kind), .byte_i(payload), .bsync_i(bsync_q), .lock_i(lock_q),
    .err_i(err_q), .act_i(act_q),
    .byte_o(byte_o), .valid_o(byte_valid_o), .eof_o(eof_o), .err_evt_o(err_evt)
  );

  link_rx_err_track #(.CNT_W(CNT_W)) u_err (
    .clk_i, .rst_ni,
    .err_evt_i(err_evt), .cnt_rd_i(cnt_rd_i), .lerr_ack_i(lerr_ack_i),
    .chg_ack_i(chg_ack_i), .lock_q_i(lock_q), .lock_d_i(lock_d),
    .act_q_i(act_q), .act_d_i(act_d),
    .cnt_o(err_cnt_o), .lerr_o(link_err_o), .chg_o(state_chg_o)
  );

  assign out_of_lock_o = ~lock_q;
  assign link_act_o    = act_q;
endmodule

// File: rtl/link_rx_parser_chk.sv
module link_rx_parser_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_rd_i,
  input logic             lerr_ack_i,
  input logic             chg_ack_i,
  input logic             byte_valid_o,
  input logic             eof_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic             link_err_o,
  input logic             state_chg_o,
  input logic             out_of_lock_o,
  input logic             link_act_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  assert_eof_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eof_o && byte_valid_o));

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cnt_rd_i || lerr_ack_i) |=>
      (err_cnt_o == $past(err_cnt_o)) || (err_cnt_o == $past(err_cnt_o) + 1'b1));

  assert_hold_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_of_lock_o |=> !byte_valid_o && !eof_o);

  assert_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_act_o && !cnt_rd_i && !lerr_ack_i) |=>
      !byte_valid_o && !eof_o && $stable(err_cnt_o));

  assert_chg_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_chg_o && !chg_ack_i) |=> state_chg_o);

  assert_sat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == CMAX && !cnt_rd_i && !lerr_ack_i) |=> err_cnt_o == CMAX);

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rd_i || lerr_ack_i) |=> err_cnt_o <= CNT_W'(1));

  assert_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o != $past(err_cnt_o) && err_cnt_o != '0) |-> link_err_o);
endmodule

bind link_rx_parser link_rx_parser_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_rd_i(cnt_rd_i), .lerr_ack_i(lerr_ack_i),
  .chg_ack_i(chg_ack_i), .byte_valid_o(byte_valid_o), .eof_o(eof_o),
  .err_cnt_o(err_cnt_o), .link_err_o(link_err_o), .state_chg_o(state_chg_o),
  .out_of_lock_o(out_of_lock_o), .link_act_o(link_act_o)
);

// File: tb/tb_link_rx_parser.sv
module tb_link_rx_parser;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] rx_char = '0;
  logic bsync = 0, lock = 0, rerr = 0, act = 0, cnt_rd = 0, lerr_ack = 0, chg_ack = 0;
  logic [7:0] byte_out;
  logic valid, eof, lerr, chg, oofl, lact;
  logic [CW-1:0] cnt;

  int n_chk = 0, n_err = 0;
  bit cmp_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_rx_parser #(.HOLD_CYC(16), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_char_i(rx_char), .rx_bsync_i(bsync),
    .rx_lock_i(lock), .rx_err_i(rerr), .rx_act_i(act), .cnt_rd_i(cnt_rd),
    .lerr_ack_i(lerr_ack), .chg_ack_i(chg_ack), .byte_o(byte_out),
    .byte_valid_o(valid), .eof_o(eof), .err_cnt_o(cnt), .link_err_o(lerr),
    .state_chg_o(chg), .out_of_lock_o(oofl), .link_act_o(lact)
  );

  function automatic logic [9:0] mk(input logic [1:0] t, input logic [7:0] b);
    logic [9:0] c;
    c[0] = t[1]; c[5] = t[0];
    c[4:1] = b[3:0]; c[9:6] = b[7:4];
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int a, input int e);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, a, e, $time);
    end
  endtask

  // reference: registered inputs, then frame state and counters
  logic [9:0] m_char;
  logic m_bs, m_lk, m_er, m_ac, m_lkd, m_acd;
  int m_st;  // 0 hunt, 1 sync, 2 hold
  int m_hc;
  logic [7:0] m_byte;
  logic m_valid, m_eof, m_lerr, m_chg;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_char = '0; m_bs = 0; m_lk = 0; m_er = 0; m_ac = 0; m_lkd = 0; m_acd = 0;
      m_st = 0; m_hc = 0; m_byte = '0; m_valid = 0; m_eof = 0;
      m_lerr = 0; m_chg = 0; m_cnt = 0;
    end else begin
      automatic logic [1:0] ty = {m_char[0], m_char[5]};
      automatic logic [7:0] b = {m_char[9:6], m_char[4:1]};
      automatic bit inc = 0;
      automatic bit fr = (m_st == 1) || m_bs;
      m_valid = 0; m_eof = 0;
      if (m_ac) begin
        if (!m_lk) begin m_st = 2; m_hc = 0; end
        else if (m_st == 2) begin if (m_hc == 15) m_st = 0; else m_hc++; end
        else if (m_er) begin inc = 1; m_st = 0; end
        else if (fr) begin
          if (ty == 2'b00) begin m_valid = 1; m_byte = b; m_st = 1; end
          else if (ty == 2'b11 && b == 8'hD0) begin m_eof = 1; m_st = 0; end
          else if (ty == 2'b11 && (b == 8'hEE || b == 8'hFF)) m_st = 1;
          else begin inc = 1; m_st = 0; end
        end
      end
      if (cnt_rd || lerr_ack) m_cnt = inc ? 1 : 0;
      else if (inc && m_cnt < 255) m_cnt++;
      if (inc) m_lerr = 1; else if (lerr_ack) m_lerr = 0;
      if ((m_lk != m_lkd) || (m_ac != m_acd)) m_chg = 1; else if (chg_ack) m_chg = 0;
      m_lkd = m_lk; m_acd = m_ac;
      m_char = rx_char; m_bs = bsync; m_lk = lock; m_er = rerr; m_ac = act;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk(valid == m_valid, "R1 valid", valid, m_valid);
      if (m_valid) chk(byte_out == m_byte, "R1 byte", byte_out, m_byte);
      chk(eof == m_eof, "R2 eof", eof, m_eof);
      chk(int'(cnt) == m_cnt, "R9 count", cnt, m_cnt);
      chk(lerr == m_lerr, "R10 lerr", lerr, m_lerr);
      chk(chg == m_chg, "R8 chg", chg, m_chg);
      chk(oofl == !m_lk, "R11 oofl", oofl, !m_lk);
      chk(lact == m_ac, "R11 act", lact, m_ac);
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic put(input logic [9:0] c, input logic bs);
    rx_char = c; bsync = bs;
    cyc();
    rx_char = mk(2'b11, 8'hEE); bsync = 0;
    cnt_rd = 0; lerr_ack = 0; chg_ack = 0; rerr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rx_char = mk(2'b11, 8'hEE);
    repeat (3) cyc();
    chk(valid == 0 && eof == 0 && cnt == 0, "R11 reset outputs", {valid, eof}, 0);
    chk(oofl == 1 && lact == 0, "R11 reset status", {oofl, lact}, 2'b10);
    rst_n = 1;
    cmp_en = 1;
    lock = 1; act = 1;
    cyc();
    chk(oofl == 0 && lact == 1, "R11 status one edge", {oofl, lact}, 2'b01);
    repeat (20) cyc();
    chg_ack = 1; cyc(); chg_ack = 0;
    cyc();
    chk(chg == 0, "R8 ack clears", chg, 0);

    // R7 / R1 / R2
    put(mk(2'b00, 8'h11), 0);
    put(mk(2'b11, 8'hFF), 1);
    chk(valid == 0, "R7 hunt ignores data", valid, 0);
    put(mk(2'b00, 8'hA5), 0);
    put(mk(2'b11, 8'hD0), 0);
    chk(valid == 1 && byte_out == 8'hA5, "R1 byte out", byte_out, 8'hA5);
    put(mk(2'b00, 8'h77), 0);
    chk(eof == 1, "R2 eof pulse", eof, 1);
    put(mk(2'b11, 8'hEE), 0);
    chk(valid == 0, "R7 after eof ignored", valid, 0);
    cyc();

    // R3 illegal
    cnt_rd = 1; put(mk(2'b11, 8'hEE), 0);
    put(mk(2'b11, 8'hFF), 1);
    put(mk(2'b01, 8'h3C), 0);
    put(mk(2'b00, 8'h55), 0);
    chk(cnt == 1 && lerr == 1, "R3 illegal counted", cnt, 1);
    put(mk(2'b11, 8'hEE), 0);
    chk(valid == 0, "R3 frame dropped", valid, 0);
    cyc();

    // R4 receive error
    put(mk(2'b11, 8'hFF), 1);
    put(mk(2'b00, 8'h10), 0);
    rerr = 1; put(mk(2'b00, 8'h44), 0);
    chk(valid == 1 && byte_out == 8'h10, "R4 data before error", byte_out, 8'h10);
    put(mk(2'b00, 8'h22), 0);
    chk(valid == 0 && cnt == 2, "R4 error counted", cnt, 2);
    put(mk(2'b11, 8'hEE), 0);
    chk(valid == 0, "R4 frame dropped", valid, 0);
    cyc();

    // R9 clear with increment
    put(mk(2'b11, 8'hFF), 1);
    put(mk(2'b10, 8'h00), 0);
    cnt_rd = 1; put(mk(2'b11, 8'hEE), 0);
    chk(cnt == 1, "R9 clear plus increment", cnt, 1);
    // R9 saturation
    rx_char = mk(2'b10, 8'h01); bsync = 1;
    repeat (300) cyc();
    bsync = 0; rx_char = mk(2'b11, 8'hEE);
    cyc(); cyc();
    chk(cnt == 8'hFF, "R9 saturates", cnt, 255);
    lerr_ack = 1; cyc(); lerr_ack = 0;
    chk(cnt == 0 && lerr == 0, "R10 ack clears", {cnt, lerr}, 0);

    // R5 settling interval
    lock = 0; cyc();
    chk(oofl == 1, "R11 oofl after drop", oofl, 1);
    cyc(); cyc();
    lock = 1;
    for (int k = 0; k < 19; k++) begin
      rx_char = mk(2'b00, 8'(k)); bsync = 1;
      cyc();
      if (k > 0)
        chk(valid == (k - 1 >= 16), "R5 settle boundary", valid, (k - 1 >= 16));
    end
    bsync = 0; rx_char = mk(2'b11, 8'hEE); cyc(); cyc();

    // R6 stall keeps frame state
    put(mk(2'b11, 8'hFF), 1);
    act = 0;
    rerr = 1; rx_char = mk(2'b00, 8'h31); cyc();
    rerr = 1; rx_char = mk(2'b01, 8'h31); cyc();
    rerr = 0; rx_char = mk(2'b00, 8'h32); cyc();
    chk(valid == 0 && cnt == 0, "R6 stalled", {valid, cnt}, 0);
    act = 1;
    put(mk(2'b00, 8'h99), 0);
    chk(chg == 1, "R8 act change flagged", chg, 1);
    put(mk(2'b11, 8'hEE), 0);
    chk(valid == 1 && byte_out == 8'h99, "R6 frame kept", byte_out, 8'h99);
    chk(cnt == 0, "R6 no errors counted", cnt, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      automatic int r = $urandom % 16;
      automatic logic [7:0] b = 8'($urandom);
      if (r < 9 || r == 15) rx_char = mk(2'b00, b);
      else if (r == 9) rx_char = mk(2'b11, 8'hD0);
      else if (r == 10) rx_char = mk(2'b11, 8'hEE);
      else if (r == 11) rx_char = mk(2'b11, 8'hFF);
      else if (r == 12) rx_char = mk(2'b01, b);
      else if (r == 13) rx_char = mk(2'b10, b);
      else rx_char = mk(2'b11, b);
      bsync = ($urandom % 6) == 0;
      rerr = ($urandom % 40) == 0;
      if (lock) lock = ($urandom % 80) != 0; else lock = ($urandom % 4) == 0;
      if (act) act = ($urandom % 60) != 0; else act = ($urandom % 4) == 0;
      cnt_rd = ($urandom % 30) == 0;
      lerr_ack = ($urandom % 40) == 0;
      chg_ack = ($urandom % 10) == 0;
      cyc();
    end
    cnt_rd = 0; lerr_ack = 0; chg_ack = 0; rerr = 0; bsync = 0;
    cyc(); cyc();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule